// File: doc/BRIEF.md
# Cycle-Stealing Counter and Interrupt Sequencer

This block sits at the instruction boundary of a small processor and decides what happens in the gap between two instructions. A set of involuntary counters lives in memory. Each counter works either as an up/down counter or as a shift register. Hardware events ask for an increment, a decrement or a shift of one counter. The block holds these requests as pending. At each boundary slot it inserts one single-operation cycle for the highest-priority pending counter. It does this by presenting the counter index and the operation to the counter storage for one clock.

When no counter is waiting, the same boundary slot can be used to take an interrupt. Five sources are arbitrated in a fixed order:

- real-time timer
- display refresh
- keypress
- uplink word complete
- hardware error

The timer and display sources are raised when the storage reports an overflow on their counters. The uplink source is raised after a full word of shifts on the uplink counter.

When an interrupt is taken, the block emits its vector, saves the program counter and marks a service routine as active. Two special-address accesses inhibit and release interrupts. A separate save-and-block instruction saves the program counter and blocks interrupts without vectoring. Resume ends service and hands the saved program counter back.

Top module: `stealcyc_irq_ctrl`

## Requirements
- R1: After reset, `cyc_vld`, `irq_take` and `pc_load` are low, no interrupt is pending, interrupts are not inhibited and no service routine is active.
- R2: A one-clock pulse on `inc_req[i]`, `dec_req[i]` or `shf_req[i]` is held as pending. The cycle after the next clock with `slot` high, `cyc_vld` pulses for one clock with `cyc_idx`=i and `cyc_op` coded increment=1, decrement=2, shift=3. That request is then cleared.
- R3: Among pending counter requests, the lowest counter index is served first. For one index, increment goes before decrement, and decrement before shift. Only one cycle is inserted per slot.
- R4: A slot with any counter request pending inserts a counter cycle and never takes an interrupt in the same slot.
- R5: `cyc_ovf` high while `cyc_vld` is high raises the timer interrupt if `cyc_idx` equals TMR_IDX (default 1), or the display interrupt if it equals DSP_IDX (default 3). An overflow on any other index raises nothing.
- R6: Every WORD_BITS-th (default 16) shift cycle inserted on counter UPL_IDX (default 12) raises the uplink interrupt. Fewer shifts raise nothing.
- R7: Pending interrupts are served in the order timer, display, keypress, uplink, error. The vector is VEC_BASE (default 0x400) plus VEC_STEP (default 4) times that rank, so 0x400, 0x404, 0x408, 0x40C and 0x410.
- R8: An interrupt is taken at a slot with no counter pending, no inhibit and no active service. `irq_take` pulses the next cycle, only the taken pending flag is cleared, and `pc_in` at that slot is saved.
- R9: `inhint` blocks interrupt takes until `relint`. Pending interrupts are kept meanwhile.
- R10: While a service routine is active, no interrupt is taken. `resume` ends service, and the next cycle `pc_load` pulses with `pc_out` equal to the saved program counter.
- R11: `edrupt` saves `pc_in` and makes service active without any `irq_take`. `relint` does not re-enable takes after it; only `resume` does.
- R12: With `slot` low, nothing is inserted or taken, however many requests are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_req | input | NCNT | Per-counter increment request pulses |
| dec_req | input | NCNT | Per-counter decrement request pulses |
| shf_req | input | NCNT | Per-counter shift request pulses |
| slot | input | 1 | Instruction boundary: one cycle may be inserted or one interrupt taken |
| cyc_ovf | input | 1 | Overflow report from counter storage for the current inserted cycle |
| err_evt | input | 1 | Hardware error event pulse |
| key_evt | input | 1 | Keypress event pulse |
| inhint | input | 1 | Inhibit interrupts (special address access) |
| relint | input | 1 | Release interrupts (special address access) |
| edrupt | input | 1 | Save program counter and block interrupts without vectoring |
| resume | input | 1 | Return from service |
| pc_in | input | AW | Current program counter |
| cyc_vld | output | 1 | Inserted counter cycle strobe |
| cyc_idx | output | clog2(NCNT) | Index of counter being serviced |
| cyc_op | output | 2 | Operation: 1 increment, 2 decrement, 3 shift |
| irq_take | output | 1 | Interrupt taken strobe |
| irq_vec | output | AW | Vector address of the taken interrupt |
| pc_load | output | 1 | Strobe to reload the program counter on resume |
| pc_out | output | AW | Saved program counter |

## Verification
The bench goes after the ordering corners. Several requests are raised on two counters in the same cycle, including an increment, decrement and shift mix on one index. A wrong encoder would serve them in the wrong order or merge them. A counter request and a pending interrupt are made to meet at one slot; a design that let interrupts win would vector before the counter cycle. The uplink path gets exactly one shift less than a word and then the last shift. An off-by-one counter would fire early or late. Inhibit, nested service and the save-and-block instruction are each paired with a `relint`. A design that treated release as the end of service would take an interrupt too soon, and one that dropped pending flags while blocked would never vector afterwards.

// File: rtl/ccirq_pkg.sv
package ccirq_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2,
    OP_SHF  = 2'd3
  } cop_t;

  localparam int NSRC    = 5;
  // rank order is the service priority
  localparam int SRC_TMR = 0;
  localparam int SRC_DSP = 1;
  localparam int SRC_KEY = 2;
  localparam int SRC_UPL = 3;
  localparam int SRC_ERR = 4;
endpackage

// File: rtl/ccirq_first.sv
module ccirq_first #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan downward so the last hit is the lowest
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ccirq_cnt_sched.sv
module ccirq_cnt_sched
  import ccirq_pkg::*;
#(
  parameter int NCNT      = 20,
  parameter int UPL_IDX   = 12,
  parameter int WORD_BITS = 16,
  localparam int IW       = $clog2(NCNT),
  localparam int CW       = $clog2(WORD_BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCNT-1:0] inc_req,
  input  logic [NCNT-1:0] dec_req,
  input  logic [NCNT-1:0] shf_req,
  input  logic            grant,
  output logic            has_req,
  output logic            cyc_vld,
  output logic [IW-1:0]   cyc_idx,
  output cop_t            cyc_op,
  output logic            word_done
);
  logic [NCNT-1:0] p_inc, p_dec, p_shf, busy;
  logic [NCNT-1:0] clr_inc, clr_dec, clr_shf;
  logic            found, issue, upl_shift;
  logic [IW-1:0]   sel;
  cop_t            op;
  logic [CW-1:0]   bit_cnt;

  assign busy    = p_inc | p_dec | p_shf;
  assign has_req = found;

  ccirq_first #(.W(NCNT), .IW(IW)) u_pick (
    .vec  (busy),
    .found(found),
    .idx  (sel)
  );

  always_comb begin
    if (p_inc[sel])      op = OP_INC;
    else if (p_dec[sel]) op = OP_DEC;
    else                 op = OP_SHF;
    issue   = grant && found;
    clr_inc = '0;
    clr_dec = '0;
    clr_shf = '0;
    if (issue) begin
      case (op)
        OP_INC:  clr_inc[sel] = 1'b1;
        OP_DEC:  clr_dec[sel] = 1'b1;
        default: clr_shf[sel] = 1'b1;
      endcase
    end
    upl_shift = issue && (op == OP_SHF) && (sel == IW'(UPL_IDX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_inc     <= '0;
      p_dec     <= '0;
      p_shf     <= '0;
      cyc_vld   <= 1'b0;
      cyc_idx   <= '0;
      cyc_op    <= OP_NONE;
      bit_cnt   <= '0;
      word_done <= 1'b0;
    end else begin
      p_inc   <= (p_inc & ~clr_inc) | inc_req;
      p_dec   <= (p_dec & ~clr_dec) | dec_req;
      p_shf   <= (p_shf & ~clr_shf) | shf_req;
      cyc_vld <= issue;
      cyc_idx <= issue ? sel : '0;
      cyc_op  <= issue ? op : OP_NONE;
      word_done <= 1'b0;
      if (upl_shift) begin
        if (bit_cnt == CW'(WORD_BITS - 1)) begin
          bit_cnt   <= '0;
          word_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R2
  issue_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_vld |-> $past(grant));

  // R6
  word_on_uplink_shift_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |-> (cyc_vld && cyc_op == OP_SHF && cyc_idx == IW'(UPL_IDX)));
endmodule

// File: rtl/ccirq_irq_ctrl.sv
module ccirq_irq_ctrl
  import ccirq_pkg::*;
#(
  parameter int AW       = 12,
  parameter int VEC_BASE = 'h400,
  parameter int VEC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_evt,
  input  logic            free_slot,
  input  logic [AW-1:0]   pc_in,
  input  logic            inhint,
  input  logic            relint,
  input  logic            edrupt,
  input  logic            resume,
  output logic            irq_take,
  output logic [AW-1:0]   irq_vec,
  output logic            pc_load,
  output logic [AW-1:0]   pc_out
);
  localparam int SW = $clog2(NSRC);

  logic [NSRC-1:0] pend, clr;
  logic            found, take, inh, active;
  logic [SW-1:0]   sel;
  logic [AW-1:0]   saved_pc;

  ccirq_first #(.W(NSRC), .IW(SW)) u_rank (
    .vec  (pend),
    .found(found),
    .idx  (sel)
  );

  always_comb begin
    take = free_slot && found && !inh && !active;
    clr  = '0;
    if (take) clr[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= '0;
      inh      <= 1'b0;
      active   <= 1'b0;
      saved_pc <= '0;
      irq_take <= 1'b0;
      irq_vec  <= '0;
      pc_load  <= 1'b0;
      pc_out   <= '0;
    end else begin
      pend     <= (pend & ~clr) | src_evt;
      irq_take <= take;
      irq_vec  <= take ? AW'(VEC_BASE + int'(sel) * VEC_STEP) : '0;
      if (inhint)      inh <= 1'b1;
      else if (relint) inh <= 1'b0;
      if (take || edrupt) begin
        saved_pc <= pc_in;
        active   <= 1'b1;
      end else if (resume) begin
        active <= 1'b0;
      end
      pc_load <= resume;
      pc_out  <= resume ? saved_pc : '0;
    end
  end

  // R10
  no_back_to_back_take_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !irq_take);

  // R9
  take_not_inhibited_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> !$past(inh));

  // R7
  vector_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (irq_vec >= AW'(VEC_BASE) &&
                  irq_vec <= AW'(VEC_BASE + (NSRC - 1) * VEC_STEP)));

  // R10
  resume_pc_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (pc_out == $past(saved_pc)));
endmodule

// File: rtl/stealcyc_irq_ctrl.sv
module stealcyc_irq_ctrl
  import ccirq_pkg::*;
#(
  parameter int NCNT      = 20,
  parameter int AW        = 12,
  parameter int TMR_IDX   = 1,
  parameter int DSP_IDX   = 3,
  parameter int UPL_IDX   = 12,
  parameter int WORD_BITS = 16,
  parameter int VEC_BASE  = 'h400,
  parameter int VEC_STEP  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCNT-1:0]         inc_req,
  input  logic [NCNT-1:0]         dec_req,
  input  logic [NCNT-1:0]         shf_req,
  input  logic                    slot,
  input  logic                    cyc_ovf,
  input  logic                    err_evt,
  input  logic                    key_evt,
  input  logic                    inhint,
  input  logic                    relint,
  input  logic                    edrupt,
  input  logic                    resume,
  input  logic [AW-1:0]           pc_in,
  output logic                    cyc_vld,
  output logic [$clog2(NCNT)-1:0] cyc_idx,
  output logic [1:0]              cyc_op,
  output logic                    irq_take,
  output logic [AW-1:0]           irq_vec,
  output logic                    pc_load,
  output logic [AW-1:0]           pc_out
);
  localparam int IW = $clog2(NCNT);

  logic            has_req, word_done;
  cop_t            op_q;
  logic [NSRC-1:0] src_evt;

  ccirq_cnt_sched #(
    .NCNT(NCNT), .UPL_IDX(UPL_IDX), .WORD_BITS(WORD_BITS)
  ) u_sched (
    .clk      (clk),
    .rst      (rst),
    .inc_req  (inc_req),
    .dec_req  (dec_req),
    .shf_req  (shf_req),
    .grant    (slot),
    .has_req  (has_req),
    .cyc_vld  (cyc_vld),
    .cyc_idx  (cyc_idx),
    .cyc_op   (op_q),
    .word_done(word_done)
  );

  assign cyc_op = op_q;

  always_comb begin
    src_evt          = '0;
    src_evt[SRC_TMR] = cyc_vld && cyc_ovf && (cyc_idx == IW'(TMR_IDX));
    src_evt[SRC_DSP] = cyc_vld && cyc_ovf && (cyc_idx == IW'(DSP_IDX));
    src_evt[SRC_KEY] = key_evt;
    src_evt[SRC_UPL] = word_done;
    src_evt[SRC_ERR] = err_evt;
  end

  ccirq_irq_ctrl #(
    .AW(AW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_irq (
    .clk      (clk),
    .rst      (rst),
    .src_evt  (src_evt),
    .free_slot(slot && !has_req),
    .pc_in    (pc_in),
    .inhint   (inhint),
    .relint   (relint),
    .edrupt   (edrupt),
    .resume   (resume),
    .irq_take (irq_take),
    .irq_vec  (irq_vec),
    .pc_load  (pc_load),
    .pc_out   (pc_out)
  );

  // R4
  one_action_per_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cyc_vld, irq_take}));
endmodule

// File: tb/stealcyc_irq_ctrl_test.sv
module stealcyc_irq_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NCNT  = 20;
  localparam int AW    = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCNT-1:0] inc_req = '0, dec_req = '0, shf_req = '0;
  logic slot = 0, cyc_ovf = 0, err_evt = 0, key_evt = 0;
  logic inhint = 0, relint = 0, edrupt = 0, resume = 0;
  logic [AW-1:0] pc_in = '0;
  logic cyc_vld, irq_take, pc_load;
  logic [$clog2(NCNT)-1:0] cyc_idx;
  logic [1:0] cyc_op;
  logic [AW-1:0] irq_vec, pc_out;

  stealcyc_irq_ctrl uut (
    .clk(clk), .rst(rst), .inc_req(inc_req), .dec_req(dec_req), .shf_req(shf_req),
    .slot(slot), .cyc_ovf(cyc_ovf), .err_evt(err_evt), .key_evt(key_evt),
    .inhint(inhint), .relint(relint), .edrupt(edrupt), .resume(resume), .pc_in(pc_in),
    .cyc_vld(cyc_vld), .cyc_idx(cyc_idx), .cyc_op(cyc_op), .irq_take(irq_take),
    .irq_vec(irq_vec), .pc_load(pc_load), .pc_out(pc_out)
  );

  always #(CLK_P / 2) clk = ~clk;

  typedef struct {
    int    kind;  // 0 counter cycle, 1 interrupt take, 2 pc reload
    int    a;
    int    b;
    string req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0, seen = 0;
  bit done = 0;

  task automatic push(input int kind, input int a, input int b, input string req);
    item_t it;
    it.kind = kind; it.a = a; it.b = b; it.req = req;
    q.push_back(it);
  endtask

  task automatic observe(input int kind, input int a, input int b);
    item_t it;
    seen++;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL unexpected: kind %0d actual %0d/%0d expected nothing", kind, a, b);
    end else begin
      it = q.pop_front();
      if (it.kind != kind || it.a != a || it.b != b) begin
        errors++;
        $display("FAIL %s: actual kind %0d %0h/%0d expected kind %0d %0h/%0d",
                 it.req, kind, a, b, it.kind, it.a, it.b);
      end
    end
  endtask

  // monitor: outputs settle after posedge, sampled on negedge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (cyc_vld)  observe(0, int'(cyc_idx), int'(cyc_op));
      if (irq_take) observe(1, int'(irq_vec), 0);
      if (pc_load)  observe(2, int'(pc_out), 0);
    end
  end

  task automatic reqv(input logic [NCNT-1:0] i, input logic [NCNT-1:0] d,
                      input logic [NCNT-1:0] s);
    @(negedge clk);
    inc_req = i; dec_req = d; shf_req = s;
    @(negedge clk);
    inc_req = '0; dec_req = '0; shf_req = '0;
  endtask

  task automatic bnd(input bit ovf);
    @(negedge clk);
    slot = 1'b1;
    @(negedge clk);
    slot = 1'b0;
    cyc_ovf = ovf;
    @(negedge clk);
    cyc_ovf = 1'b0;
  endtask

  // 0 key, 1 err, 2 inhint, 3 relint, 4 edrupt, 5 resume
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: key_evt = 1; 1: err_evt = 1; 2: inhint = 1;
      3: relint = 1;  4: edrupt = 1;  default: resume = 1;
    endcase
    @(negedge clk);
    key_evt = 0; err_evt = 0; inhint = 0; relint = 0; edrupt = 0; resume = 0;
  endtask

  task automatic quiet(input string req);
    int s0;
    s0 = seen;
    bnd(0);
    repeat (2) @(negedge clk);
    checks++;
    if (seen != s0 || q.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d events expected 0 events", req, seen - s0);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung run expected completion");
    finish_run();
  end

  localparam logic [NCNT-1:0] ONE = 1;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (cyc_vld || irq_take || pc_load) begin
      errors++;
      $display("FAIL R1: actual %b%b%b expected 000", cyc_vld, irq_take, pc_load);
    end

    // R12: pending request waits for a slot
    reqv(ONE << 5, '0, '0);
    repeat (5) @(negedge clk);
    checks++;
    if (seen != 0) begin
      errors++;
      $display("FAIL R12: actual %0d events expected 0", seen);
    end
    push(0, 5, 1, "R2");
    bnd(0);

    // R3: lowest index first, inc before dec before shift
    reqv(ONE << 7, (ONE << 2) | (ONE << 7), ONE << 2);
    push(0, 2, 2, "R3"); push(0, 2, 3, "R3");
    push(0, 7, 1, "R3"); push(0, 7, 2, "R3");
    repeat (4) bnd(0);

    // R5 timer overflow, R4 counter wins over pending interrupt
    reqv(ONE << 1, '0, '0);
    push(0, 1, 1, "R5");
    bnd(1);
    pulse(0);
    reqv(ONE << 4, '0, '0);
    push(0, 4, 1, "R4");
    bnd(0);
    pc_in = 12'd100;
    push(1, 'h400, 0, "R7");
    bnd(0);
    quiet("R10");
    push(2, 100, 0, "R10");
    pulse(5);
    pc_in = 12'd200;
    push(1, 'h408, 0, "R7");
    bnd(0);
    push(2, 200, 0, "R8");
    pulse(5);

    // R5 display overflow, R7 display ahead of error
    pulse(1);
    reqv(ONE << 3, '0, '0);
    push(0, 3, 1, "R5");
    bnd(1);
    push(1, 'h404, 0, "R7");
    bnd(0);
    push(2, 200, 0, "R10");
    pulse(5);
    push(1, 'h410, 0, "R7");
    bnd(0);
    push(2, 200, 0, "R10");
    pulse(5);

    // R5 overflow on unmapped counter raises nothing
    reqv(ONE << 5, '0, '0);
    push(0, 5, 1, "R5");
    bnd(1);
    quiet("R5");

    // R9 inhibit and release
    pulse(2);
    pulse(1);
    quiet("R9");
    pulse(3);
    pc_in = 12'd300;
    push(1, 'h410, 0, "R9");
    bnd(0);
    push(2, 300, 0, "R9");
    pulse(5);

    // R6 uplink word
    for (int k = 0; k < 15; k++) begin
      reqv('0, '0, ONE << 12);
      push(0, 12, 3, "R6");
      bnd(0);
    end
    quiet("R6");
    reqv('0, '0, ONE << 12);
    push(0, 12, 3, "R6");
    bnd(0);
    push(1, 'h40C, 0, "R6");
    bnd(0);
    push(2, 300, 0, "R6");
    pulse(5);

    // R11 save-and-block
    pc_in = 12'd500;
    pulse(4);
    pc_in = 12'd600;
    pulse(0);
    quiet("R11");
    pulse(3);
    quiet("R11");
    push(2, 500, 0, "R11");
    pulse(5);
    push(1, 'h408, 0, "R11");
    bnd(0);
    push(2, 600, 0, "R8");
    pulse(5);

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d missing events expected 0", q.size());
    end
    finish_run();
  end
endmodule